// File: doc/BRIEF.md
# Half-Precision Sign-Injection and Move Unit

This unit handles the bit-level half-precision operations of a floating-point pipe that need no rounding and raise no exceptions. A 16-bit value sits in the low half-word of a 64-bit register slot. The unit offers three sign-injection forms:

- copy the sign of the second operand,
- copy the inverted sign of the second operand,
- XOR the two signs.

When the two source register indices match, these three forms become move, negate and absolute value. The unit also moves raw bit patterns between the float and integer register files. Each accepted request produces a registered result one clock later.

A mode input picks how float values are stored. In float-file style, a value must be NaN-boxed: every bit above bit 15 is one. An operand that fails this test is treated as the canonical half NaN. In integer-file style, operands are taken as they are, and every sign-injection result is sign-extended from bit 15. A second input picks the integer width for the float-to-integer move.

Top module: `hsgn_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid_o` and `illegal_o` are 0 and `result_o` is all zeros.
- R2: A request with `valid_i`=1 shows its result on `result_o`/`illegal_o` after exactly one rising edge, with `valid_o`=1. A cycle with `valid_i`=0 leaves `result_o` and `illegal_o` unchanged and drives `valid_o` to 0 one edge later.
- R3: With `int_mode_i`=0, an operand whose bits 63..16 are not all ones is replaced before use by 0xFFFF_FFFF_FFFF_7E00.
- R4: Opcode 3'd0 (sign copy) with unequal indices returns bits 14..0 of checked operand A and bits 63..15 of checked operand B.
- R5: Opcode 3'd1 (inverted sign copy) with unequal indices returns checked operand A with bit 15 set to the inverse of checked operand B's bit 15.
- R6: Opcode 3'd2 (sign XOR) with unequal indices returns checked operand A with bit 15 XORed with checked operand B's bit 15.
- R7: With equal indices:
  - opcode 3'd0 returns checked operand A,
  - opcode 3'd1 returns it with bit 15 flipped,
  - opcode 3'd2 returns it with bit 15 cleared.
- R8: With `int_mode_i`=1, operands are not checked. Each result of opcodes 3'd0..3'd2 is the 16-bit result of R4–R7 sign-extended from bit 15 to 64 bits.
- R9: Opcode 3'd3 (float to integer move) sign-extends bits 15..0 of operand A.
  - With `narrow_i`=0, it extends to 64 bits.
  - With `narrow_i`=1, it extends to 32 bits, and bits 63..32 are zero.
  - There is no box check and no mode effect.
- R10: Opcode 3'd4 (integer to float move) returns bits 15..0 of operand A with bits 63..16 forced to one, in either mode and either width.
- R11: Opcodes 3'd5..3'd7 return an all-zero result with `illegal_o`=1. Every other opcode returns `illegal_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| int_mode_i | input | 1 | 1: values live in integer registers (sign-extended); 0: NaN-boxed float registers |
| narrow_i | input | 1 | 1: 32-bit integer width for the float-to-integer move |
| rs1_idx_i | input | 5 | Register index of operand A |
| rs2_idx_i | input | 5 | Register index of operand B |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| valid_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Unsupported opcode flag |
| result_o | output | 64 | Result |

## Verification
The hardest situation to reach is a malformed NaN box that differs from a valid box in a single upper bit. The same case is needed with identical register indices, where only operand A matters. Uniform random 64-bit operands are almost never valid boxes, and they almost never miss being one by a single bit.

The stimulus therefore draws each operand from three classes:
- a valid box,
- a box with one random upper bit cleared,
- fully random bits.

It also forces equal indices on a share of the requests. Directed cases add a NaN box with a flipped sign, a zero upper half, and the narrow move of a negative value.

// File: rtl/hsgn_pkg.sv
package hsgn_pkg;

  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    OP_SGNJ  = 3'd0,
    OP_SGNJN = 3'd1,
    OP_SGNJX = 3'd2,
    OP_F2X   = 3'd3,
    OP_X2F   = 3'd4
  } hsgn_op_e;

  // canonical quiet half NaN pattern
  localparam logic [HALF_W-1:0] HALF_QNAN = 16'h7E00;

  function automatic logic is_sign_op(input logic [2:0] op);
    return (op == OP_SGNJ) || (op == OP_SGNJN) || (op == OP_SGNJX);
  endfunction

  function automatic logic is_legal_op(input logic [2:0] op);
    return is_sign_op(op) || (op == OP_F2X) || (op == OP_X2F);
  endfunction

endpackage

// File: rtl/hsgn_box_check.sv
module hsgn_box_check #(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] raw_i,
  input  logic            check_en_i,
  output logic [FLEN-1:0] checked_o,
  output logic            box_bad_o
);
  import hsgn_pkg::*;

  localparam int UPPER_W = FLEN - HALF_W;

  function automatic logic upper_all_ones(input logic [FLEN-1:0] v);
    return &v[FLEN-1:HALF_W];
  endfunction

  function automatic logic [FLEN-1:0] boxed_qnan();
    return {{UPPER_W{1'b1}}, HALF_QNAN};
  endfunction

  assign box_bad_o = check_en_i && !upper_all_ones(raw_i);
  assign checked_o = box_bad_o ? boxed_qnan() : raw_i;

endmodule

// File: rtl/hsgn_inject.sv
module hsgn_inject #(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] a_i,
  input  logic [FLEN-1:0] b_i,
  input  logic [2:0]      op_i,
  input  logic            same_idx_i,
  input  logic            int_mode_i,
  output logic [FLEN-1:0] res_o,
  output logic            new_sign_o
);
  import hsgn_pkg::*;

  localparam int SB = HALF_W - 1;   // sign bit position
  localparam int UPPER_W = FLEN - HALF_W;

  function automatic logic pick_sign(input logic [2:0] op, input logic same,
                                     input logic sa, input logic sb);
    logic s;
    case (op)
      OP_SGNJ:  s = same ? sa : sb;
      OP_SGNJN: s = same ? ~sa : ~sb;
      default:  s = same ? 1'b0 : (sa ^ sb);
    endcase
    return s;
  endfunction

  function automatic logic [FLEN-1:0] sext_half(input logic [HALF_W-1:0] h);
    return {{UPPER_W{h[SB]}}, h};
  endfunction

  logic [FLEN-1:0] upper_src;
  logic [FLEN-1:0] merged;

  assign new_sign_o = pick_sign(op_i, same_idx_i, a_i[SB], b_i[SB]);

  // plain copy with distinct indices keeps operand B's upper bits
  assign upper_src = ((op_i == OP_SGNJ) && !same_idx_i) ? b_i : a_i;

  always_comb begin
    merged = upper_src;
    merged[SB-1:0] = a_i[SB-1:0];
    merged[SB] = new_sign_o;
  end

  assign res_o = int_mode_i ? sext_half(merged[HALF_W-1:0]) : merged;

endmodule

// File: rtl/hsgn_move.sv
module hsgn_move #(
  parameter int FLEN = 64
) (
  input  logic [hsgn_pkg::HALF_W-1:0] half_i,
  input  logic [2:0]                  op_i,
  input  logic                        narrow_i,
  output logic [FLEN-1:0]             res_o
);
  import hsgn_pkg::*;

  localparam int NARROW_W = FLEN / 2;
  localparam int WIDE_EXT = FLEN - HALF_W;
  localparam int NARROW_EXT = NARROW_W - HALF_W;

  function automatic logic [FLEN-1:0] to_int(input logic [HALF_W-1:0] h,
                                             input logic nar);
    logic [FLEN-1:0] v;
    if (nar) v = {{NARROW_W{1'b0}}, {NARROW_EXT{h[HALF_W-1]}}, h};
    else     v = {{WIDE_EXT{h[HALF_W-1]}}, h};
    return v;
  endfunction

  function automatic logic [FLEN-1:0] to_float(input logic [HALF_W-1:0] h);
    return {{WIDE_EXT{1'b1}}, h};
  endfunction

  always_comb begin
    if (op_i == OP_F2X) res_o = to_int(half_i, narrow_i);
    else                res_o = to_float(half_i);
  end

endmodule

// File: rtl/hsgn_unit.sv
module hsgn_unit #(
  parameter int FLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic             int_mode_i,
  input  logic             narrow_i,
  input  logic [IDX_W-1:0] rs1_idx_i,
  input  logic [IDX_W-1:0] rs2_idx_i,
  input  logic [FLEN-1:0]  opa_i,
  input  logic [FLEN-1:0]  opb_i,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [FLEN-1:0]  result_o
);
  import hsgn_pkg::*;

  localparam int NOPS = 2;
  localparam int UPPER_W = FLEN - HALF_W;
  localparam int SEXT_W = FLEN - HALF_W + 1;
  localparam int NARROW_W = FLEN / 2;

  logic [FLEN-1:0] raw_ops [NOPS];
  logic [FLEN-1:0] chk_ops [NOPS];
  logic [NOPS-1:0] box_bad;

  assign raw_ops[0] = opa_i;
  assign raw_ops[1] = opb_i;

  generate
    for (genvar g = 0; g < NOPS; g++) begin : g_box
      hsgn_box_check #(.FLEN(FLEN)) box_i (
        .raw_i      (raw_ops[g]),
        .check_en_i (!int_mode_i),
        .checked_o  (chk_ops[g]),
        .box_bad_o  (box_bad[g])
      );
    end
  endgenerate

  logic            same_idx;
  logic            sign_op;
  logic            legal_op;
  logic            inj_sign;
  logic [FLEN-1:0] inj_res;
  logic [FLEN-1:0] mov_res;
  logic [FLEN-1:0] nxt_res;

  assign same_idx = (rs1_idx_i == rs2_idx_i);
  assign sign_op  = is_sign_op(op_i);
  assign legal_op = is_legal_op(op_i);

  hsgn_inject #(.FLEN(FLEN)) inj_i (
    .a_i        (chk_ops[0]),
    .b_i        (chk_ops[1]),
    .op_i       (op_i),
    .same_idx_i (same_idx),
    .int_mode_i (int_mode_i),
    .res_o      (inj_res),
    .new_sign_o (inj_sign)
  );

  hsgn_move #(.FLEN(FLEN)) mov_i (
    .half_i   (opa_i[HALF_W-1:0]),
    .op_i     (op_i),
    .narrow_i (narrow_i),
    .res_o    (mov_res)
  );

  always_comb begin
    if (!legal_op)    nxt_res = '0;
    else if (sign_op) nxt_res = inj_res;
    else              nxt_res = mov_res;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= !legal_op;
        result_o  <= nxt_res;
      end
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(illegal_o)));

  // R11
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (result_o == '0));

  // R3
  float_box_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !int_mode_i && sign_op) |=> (&result_o[FLEN-1:HALF_W]));

  // R3
  bad_box_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && box_bad[0] && same_idx && op_i == OP_SGNJN)
      |=> (result_o[HALF_W-1:0] == (HALF_QNAN | 16'h8000)));

  // R8
  int_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && int_mode_i && sign_op) |=>
      ($countones(result_o[FLEN-1:HALF_W-1]) == 0 ||
       $countones(result_o[FLEN-1:HALF_W-1]) == SEXT_W));

  // R7
  abs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && same_idx && op_i == OP_SGNJX) |=> !result_o[HALF_W-1]);

  // R9
  narrow_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && narrow_i && op_i == OP_F2X) |=> (result_o[FLEN-1:NARROW_W] == '0));

  // R10
  x2f_box_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_X2F) |=> (result_o[FLEN-1:HALF_W] == {UPPER_W{1'b1}}));

  // R4
  sign_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sign_op) |=> (result_o[HALF_W-1] == $past(inj_sign)));

endmodule

// File: tb/hsgn_unit_tb.sv
module hsgn_unit_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        int_mode_i = 1'b0;
  logic        narrow_i = 1'b0;
  logic [4:0]  rs1_idx_i = '0;
  logic [4:0]  rs2_idx_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        valid_o;
  logic        illegal_o;
  logic [63:0] result_o;

  int checks = 0;
  int failures = 0;

  localparam longint unsigned BOX  = 64'hFFFF_FFFF_FFFF_0000;
  localparam longint unsigned QNAN = 64'hFFFF_FFFF_FFFF_7E00;

  always #5 clk_i = ~clk_i;

  hsgn_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .op_i, .int_mode_i, .narrow_i,
    .rs1_idx_i, .rs2_idx_i, .opa_i, .opb_i,
    .valid_o, .illegal_o, .result_o
  );

  task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // behavioural model built from the requirement text
  function automatic longint unsigned model(input int op, input bit im, input bit nar,
      input bit same, input longint unsigned a, input longint unsigned b, output bit ill);
    longint unsigned ca, cb, hi, r, lo;
    bit sa, sb, ns;
    ill = 0;
    ca = a; cb = b;
    if (!im) begin
      if ((a >> 16) != 64'h0000_FFFF_FFFF_FFFF) ca = QNAN;
      if ((b >> 16) != 64'h0000_FFFF_FFFF_FFFF) cb = QNAN;
    end
    sa = ca[15]; sb = cb[15];
    r = 0;
    if (op <= 2) begin
      if (same) ns = (op == 0) ? sa : (op == 1) ? !sa : 1'b0;
      else      ns = (op == 0) ? sb : (op == 1) ? !sb : (sa ^ sb);
      hi = (op == 0 && !same) ? cb : ca;
      r = (hi & ~64'hFFFF) + (ns ? 64'h8000 : 64'h0) + (ca % 64'h8000);
      if (im) begin
        lo = r % 64'h10000;
        r = (lo >= 64'h8000) ? (lo | BOX) : lo;
      end
    end else if (op == 3) begin
      lo = a % 64'h10000;
      r = (lo >= 64'h8000) ? (lo | BOX) : lo;
      if (nar) r = r % 64'h1_0000_0000;
    end else if (op == 4) begin
      r = (a % 64'h10000) | BOX;
    end else begin
      ill = 1;
    end
    return r;
  endfunction

  function automatic string tag_of(input int op, input bit im, input bit same,
                                   input longint unsigned a, input longint unsigned b);
    if (op >= 5) return "R11";
    if (op == 4) return "R10";
    if (op == 3) return "R9";
    if (im) return "R8";
    if ((a >> 16) != 64'h0000_FFFF_FFFF_FFFF || (b >> 16) != 64'h0000_FFFF_FFFF_FFFF)
      return "R3";
    if (same) return "R7";
    if (op == 0) return "R4";
    if (op == 1) return "R5";
    return "R6";
  endfunction

  task automatic xact(input int op, input bit im, input bit nar, input int i1, input int i2,
                      input longint unsigned a, input longint unsigned b);
    longint unsigned exp;
    bit ill;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'(op); int_mode_i = im; narrow_i = nar;
    rs1_idx_i = 5'(i1); rs2_idx_i = 5'(i2); opa_i = a; opb_i = b;
    exp = model(op, im, nar, i1 == i2, a, b, ill);
    @(posedge clk_i);
    #1;
    check(tag_of(op, im, i1 == i2, a, b), {valid_o, illegal_o, result_o}, {1'b1, ill, exp});
    valid_i = 1'b0;
  endtask

  function automatic longint unsigned rnd_op();
    int k;
    longint unsigned v;
    k = $urandom_range(0, 2);
    v = {$urandom, $urandom};
    if (k == 0) v = v | BOX;
    else if (k == 1) begin
      v = v | BOX;
      v[$urandom_range(16, 63)] = 1'b0;
    end
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [65:0] held;
    // R1 reset state during and right after reset
    repeat (3) @(posedge clk_i);
    #1 check("R1", {valid_o, illegal_o, result_o}, 66'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    #1 check("R1", {valid_o, illegal_o, result_o}, 66'd0);

    // directed cases
    xact(0, 0, 0, 3, 3, 64'h0000_0000_0000_3C00, 0);       // R3 bad box, move
    xact(1, 0, 0, 3, 3, 64'hFFFF_FFFF_FFFE_3C00, 0);       // R3 one bit off, negate
    xact(0, 0, 0, 1, 2, 64'hFFFF_FFFF_FFFF_3C00, 64'hFFFF_FFFF_FFFF_8001); // R4
    xact(1, 0, 0, 1, 2, 64'hFFFF_FFFF_FFFF_BC00, 64'hFFFF_FFFF_FFFF_8001); // R5
    xact(2, 0, 0, 1, 2, 64'hFFFF_FFFF_FFFF_BC00, 64'hFFFF_FFFF_FFFF_8000); // R6
    xact(2, 0, 0, 4, 4, 64'hFFFF_FFFF_FFFF_FC00, 0);       // R7 abs
    xact(0, 1, 0, 1, 2, 64'h0000_0000_0000_3C00, 64'h0000_0000_0000_8000); // R8
    xact(3, 0, 1, 0, 0, 64'h1234_5678_9ABC_8123, 0);       // R9 narrow
    xact(3, 1, 0, 0, 0, 64'h0000_0000_0000_8123, 0);       // R9 wide
    xact(4, 1, 1, 0, 0, 64'h0000_0000_0000_4567, 0);       // R10
    xact(6, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);       // R11

    // R2 hold: idle cycle with changed inputs
    held = {1'b1, illegal_o, result_o};
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 3'd4; opa_i = 64'h1; opb_i = 64'h2;
    @(posedge clk_i); #1;
    check("R2", {valid_o, illegal_o, result_o}, {1'b0, held[64:0]});

    // random sweep across every opcode, mode and width
    for (int op = 0; op < 8; op++) begin
      for (int m = 0; m < 4; m++) begin
        for (int n = 0; n < 40; n++) begin
          int i1, i2;
          i1 = $urandom_range(0, 31);
          i2 = ($urandom_range(0, 3) == 0) ? i1 : $urandom_range(0, 31);
          xact(op, m[0], m[1], i1, i2, rnd_op(), rnd_op());
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule